// File: doc/BRIEF.md
# Adaptive Weighted-Bit Reconstruction for a Sub-Binary SAR Channel

This block is the digital back end of one channel of a successive-approximation converter whose capacitor ladder uses a radix below two. For every conversion it takes the raw comparator decisions and builds the output word. Each decision bit that is 1 adds its own signed weight to the result, and a signed channel offset is added on top. The redundancy of the sub-binary ladder means that capacitor mismatch can be repaired entirely in these digital weights.

A background least-mean-square loop keeps the weights and the offset trimmed. Each produced sample is compared against a reference value that arrives with the raw bits. When adaptation is enabled for that sample, the weights of the bits that were set and the offset each take a scaled step against the error. This corrects static nonlinearity, gain and offset of the channel. An interleaved converter places one instance per conversion channel, including the calibration spares, so every channel holds its own set of coefficients.

All values use signed fixed point with `FRAC` fractional bits. The weight set is read back on a flat bus so that the channel can be monitored.

Top module: `adcWeightRecon`

## Requirements
- R1: While `rstN` is low and after it is released, weight i holds its nominal value times 2^FRAC. Weight 10 is 512. Each lower weight is the next higher one divided by 1.85 and rounded to nearest, which gives 512, 277, 150, 81, 44, 24, 13, 7, 4, 2, 1 for weights 10 down to 0. The offset reads 0 and `outValid` is low.
- R2: `outSample` equals the offset plus the sum of weight i over every bit i of `rawBits` that is 1. It uses the weights in force on the cycle after the input is accepted.
- R3: A cycle with `rawValid` high produces exactly one cycle of `outValid` two clock cycles later. No `outValid` appears without such an input.
- R4: `outSample` holds its value in every cycle where `outValid` is low.
- R5: When the input was accepted with `adaptEn` high, the error e = `outSample` − `refSample` is formed when the sample is output. On the next clock edge, each weight whose bit was 1 becomes w − (e >>> MU_SHIFT), using an arithmetic shift. Weights whose bit was 0 are left unchanged. Weights change at no other time.
- R6: On that same edge the offset becomes offset − (e >>> MU_SHIFT).
- R7: When the input was accepted with `adaptEn` low, the weights and the offset do not change.
- R8: An update that would pass a signed WW-bit limit leaves the weight or offset at −2^(WW−1) or at 2^(WW−1)−1 instead of wrapping.
- R9: `weightsFlat` carries weight i in bits [i·WW +: WW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawValid | input | 1 | Raw decision vector is present this cycle |
| rawBits | input | NBITS | Comparator decisions, bit i uses weight i |
| refSample | input | OW | Signed reference for this conversion, FRAC fractional bits |
| adaptEn | input | 1 | Allow this conversion to update the coefficients |
| outValid | output | 1 | Corrected sample is present |
| outSample | output | OW | Signed corrected sample, FRAC fractional bits |
| weightsFlat | output | NBITS*WW | Current signed weights, packed |
| offsetOut | output | WW | Current signed offset |

## Verification
A corrupted weight shows up in `outSample` only for codes that have that bit set. The stimulus therefore mixes sparse, dense and alternating codes, so that every coefficient contributes to some checked sample. An update that is misdirected, too large, or lands on the wrong bit appears on `weightsFlat` and `offsetOut` one cycle after the output strobe. Every coefficient is compared after every conversion, so a fault shows within three cycles of the input that caused it. Wrapping instead of saturation shows as a sign flip on the first conversion with a large error.

// File: rtl/reconPkg.sv
package reconPkg;

  typedef struct packed {
    logic capture;
    logic produce;
    logic update;
  } strobes_t;

  // nominal sub-binary weight of bit idx, scaled by 2^frac
  function automatic int nominalWeight(int idx, int nbits, int frac);
    int v;
    v = 512;
    for (int k = nbits - 1; k > idx; k--) begin
      v = (v * 200 + 185) / 370;
    end
    return v << frac;
  endfunction

endpackage

// File: rtl/reconCtrl.sv
module reconCtrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rawValid,
  input  logic                adaptEn,
  output reconPkg::strobes_t  strobes,
  output logic                outValid
);
  logic stage1Valid;
  logic stage1Adapt;
  logic stage2Adapt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage1Adapt <= 1'b0;
      outValid    <= 1'b0;
      stage2Adapt <= 1'b0;
    end else begin
      stage1Valid <= rawValid;
      stage1Adapt <= rawValid & adaptEn;
      outValid    <= stage1Valid;
      stage2Adapt <= stage1Valid & stage1Adapt;
    end
  end

  always_comb begin
    strobes.capture = rawValid;
    strobes.produce = stage1Valid;
    strobes.update  = outValid & stage2Adapt;
  end
endmodule

// File: rtl/reconCell.sv
module reconCell #(
  parameter int WW = 20,
  parameter int DW = 25,
  parameter logic signed [WW-1:0] INIT = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 update,
  input  logic signed [DW-1:0] delta,
  output logic signed [WW-1:0] value
);
  localparam int XW = ((WW > DW) ? WW : DW) + 1;

  logic signed [XW-1:0] wide;
  logic signed [WW-1:0] clamped;

  always_comb begin
    wide = XW'(value) - XW'(delta);
    if (!wide[XW-1] && (|wide[XW-2:WW-1])) begin
      clamped = {1'b0, {(WW-1){1'b1}}};
    end else if (wide[XW-1] && !(&wide[XW-2:WW-1])) begin
      clamped = {1'b1, {(WW-1){1'b0}}};
    end else begin
      clamped = wide[WW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) value <= INIT;
    else if (update) value <= clamped;
  end
endmodule

// File: rtl/reconDatapath.sv
module reconDatapath #(
  parameter int NBITS    = 11,
  parameter int FRAC     = 8,
  parameter int WW       = 20,
  parameter int OW       = 24,
  parameter int MU_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  reconPkg::strobes_t      strobes,
  input  logic [NBITS-1:0]        rawBits,
  input  logic signed [OW-1:0]    refSample,
  output logic signed [OW-1:0]    outSample,
  output logic [NBITS*WW-1:0]     weightsFlat,
  output logic signed [WW-1:0]    offsetOut
);
  localparam int EW = OW + 1;

  logic [NBITS-1:0]     bits1;
  logic [NBITS-1:0]     bits2;
  logic signed [OW-1:0] ref1;
  logic signed [OW-1:0] ref2;
  logic signed [OW-1:0] acc;
  logic signed [EW-1:0] errVal;
  logic signed [EW-1:0] step;
  logic signed [WW-1:0] weightVal [NBITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bits1     <= '0;
      ref1      <= '0;
      bits2     <= '0;
      ref2      <= '0;
      outSample <= '0;
    end else begin
      if (strobes.capture) begin
        bits1 <= rawBits;
        ref1  <= refSample;
      end
      if (strobes.produce) begin
        bits2     <= bits1;
        ref2      <= ref1;
        outSample <= acc;
      end
    end
  end

  always_comb begin
    acc = OW'(offsetOut);
    for (int i = 0; i < NBITS; i++) begin
      if (bits1[i]) acc = acc + OW'(weightVal[i]);
    end
  end

  always_comb begin
    errVal = EW'(outSample) - EW'(ref2);
    step   = errVal >>> MU_SHIFT;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_weight
    reconCell #(
      .WW  (WW),
      .DW  (EW),
      .INIT(WW'(reconPkg::nominalWeight(i, NBITS, FRAC)))
    ) i_cell (
      .clk   (clk),
      .rstN  (rstN),
      .update(strobes.update & bits2[i]),
      .delta (step),
      .value (weightVal[i])
    );
    assign weightsFlat[i*WW +: WW] = weightVal[i];
  end

  reconCell #(
    .WW  (WW),
    .DW  (EW),
    .INIT('0)
  ) i_offset (
    .clk   (clk),
    .rstN  (rstN),
    .update(strobes.update),
    .delta (step),
    .value (offsetOut)
  );
endmodule

// File: rtl/adcWeightRecon.sv
module adcWeightRecon #(
  parameter int NBITS    = 11,
  parameter int FRAC     = 8,
  parameter int WW       = 20,
  parameter int OW       = 24,
  parameter int MU_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rawValid,
  input  logic [NBITS-1:0]     rawBits,
  input  logic signed [OW-1:0] refSample,
  input  logic                 adaptEn,
  output logic                 outValid,
  output logic signed [OW-1:0] outSample,
  output logic [NBITS*WW-1:0]  weightsFlat,
  output logic signed [WW-1:0] offsetOut
);
  reconPkg::strobes_t strobes;

  reconCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rawValid(rawValid),
    .adaptEn (adaptEn),
    .strobes (strobes),
    .outValid(outValid)
  );

  reconDatapath #(
    .NBITS   (NBITS),
    .FRAC    (FRAC),
    .WW      (WW),
    .OW      (OW),
    .MU_SHIFT(MU_SHIFT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rawBits    (rawBits),
    .refSample  (refSample),
    .outSample  (outSample),
    .weightsFlat(weightsFlat),
    .offsetOut  (offsetOut)
  );
endmodule

// File: rtl/adcWeightReconChk.sv
module adcWeightReconChk #(
  parameter int NBITS = 11,
  parameter int WW    = 20,
  parameter int OW    = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rawValid,
  input logic [NBITS-1:0]     rawBits,
  input logic signed [OW-1:0] refSample,
  input logic                 adaptEn,
  input logic                 outValid,
  input logic signed [OW-1:0] outSample,
  input logic [NBITS*WW-1:0]  weightsFlat,
  input logic signed [WW-1:0] offsetOut
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |-> ##2 outValid); // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |-> ##2 !outValid); // R3

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample)); // R4

  AST_IDLE_COEFFS: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |=> ($stable(weightsFlat) && $stable(offsetOut))); // R5

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(adaptEn, 2)) |=> ($stable(weightsFlat) && $stable(offsetOut))); // R7

  AST_OFFSET_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(rawValid, 2) && $past(adaptEn, 2) && (outSample > $past(refSample, 2)))
      |=> (offsetOut <= $past(offsetOut))); // R6
endmodule

bind adcWeightRecon adcWeightReconChk #(.NBITS(NBITS), .WW(WW), .OW(OW)) i_chk (.*);

// File: tb/test_adcWeightRecon.sv
module test_adcWeightRecon;
  localparam int NBITS = 11;
  localparam int FRAC  = 8;
  localparam int WW    = 20;
  localparam int OW    = 24;
  localparam int MU    = 4;
  localparam int WMAX  = (1 << (WW - 1)) - 1;
  localparam int WMIN  = -(1 << (WW - 1));
  localparam int NV    = 12;

  localparam logic [NBITS-1:0] V_BITS [NV] = '{
    11'h000, 11'h7FF, 11'h400, 11'h2AA, 11'h555, 11'h001,
    11'h7FF, 11'h400, 11'h3F0, 11'h00F, 11'h000, 11'h555};
  localparam int V_REF [NV] = '{
    5000, 0, -7, 123456, 1, 99,
    280000, 130000, 200000, -5000, 1000, 100000};
  localparam bit V_ADAPT [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int NOMINAL [NBITS] = '{1, 2, 4, 7, 13, 24, 44, 81, 150, 277, 512};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawValid = 1'b0;
  logic [NBITS-1:0] rawBits = '0;
  logic signed [OW-1:0] refSample = '0;
  logic adaptEn = 1'b0;
  logic outValid;
  logic signed [OW-1:0] outSample;
  logic [NBITS*WW-1:0] weightsFlat;
  logic signed [WW-1:0] offsetOut;

  int total = 0;
  int bad = 0;
  int wM [NBITS];
  int offM;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adcWeightRecon i_adcWeightRecon (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .rawBits(rawBits),
    .refSample(refSample), .adaptEn(adaptEn), .outValid(outValid),
    .outSample(outSample), .weightsFlat(weightsFlat), .offsetOut(offsetOut));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(longint v);
    if (v > WMAX) return WMAX;
    if (v < WMIN) return WMIN;
    return int'(v);
  endfunction

  function automatic int wPort(int i);
    return int'($signed(weightsFlat[i*WW +: WW]));
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NBITS; i++) wM[i] = NOMINAL[i] << FRAC;
    offM = 0;
  endtask

  // R9: weight i is compared through slice [i*WW +: WW]
  task automatic checkCoeffs(input string req);
    for (int i = 0; i < NBITS; i++) check(req, $sformatf("weight%0d", i), wPort(i), wM[i]);
    check(req, "offset", offsetOut, offM);
  endtask

  task automatic runSample(input logic [NBITS-1:0] b, input int r, input bit a, input string req);
    longint expOut;
    longint e;
    longint st;
    @(negedge clk);
    rawValid = 1'b1; rawBits = b; refSample = OW'(r); adaptEn = a;
    @(negedge clk);
    rawValid = 1'b0; adaptEn = 1'b0; rawBits = '0; refSample = '0;
    check("R3", "outValid one cycle after input", outValid, 0);
    @(negedge clk);
    expOut = offM;
    for (int i = 0; i < NBITS; i++) if (b[i]) expOut += wM[i];
    check("R3", "outValid two cycles after input", outValid, 1);
    check("R2", $sformatf("outSample code %03h", b), outSample, expOut);
    e = expOut - longint'(r);
    st = e >>> MU;
    if (a) begin
      for (int i = 0; i < NBITS; i++) if (b[i]) wM[i] = sat(longint'(wM[i]) - st);
      offM = sat(longint'(offM) - st);
    end
    @(negedge clk);
    check("R3", "outValid single cycle", outValid, 0);
    checkCoeffs(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic signed [OW-1:0] held;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid in reset", outValid, 0);
    checkCoeffs("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", outValid, 0);
    checkCoeffs("R1");

    // table walk: frozen rows exercise R2/R7, adapting rows R5/R6
    for (int k = 0; k < NV; k++) begin
      runSample(V_BITS[k], V_REF[k], V_ADAPT[k], V_ADAPT[k] ? "R5" : "R7");
    end

    // R4: output held while idle
    held = outSample;
    repeat (5) @(negedge clk);
    check("R4", "outSample held", outSample, held);

    // R7: huge error but adaptation off
    runSample(11'h7FF, -8000000, 1'b0, "R7");

    // R8: negative saturation of low weights and offset
    runSample(11'h7FF, -(1 << (OW - 1)), 1'b1, "R8");
    check("R8", "weight0 at min", wPort(0), WMIN);
    check("R8", "offset at min", offsetOut, WMIN);
    runSample(11'h7FF, -(1 << (OW - 1)), 1'b1, "R8");
    check("R8", "weight10 at min", wPort(10), WMIN);
    // R8: drive toward positive limit
    for (int k = 0; k < 3; k++) runSample(11'h7FF, (1 << (OW - 1)) - 1, 1'b1, "R8");
    check("R8", "weight0 at max", wPort(0), WMAX);
    check("R8", "offset at max", offsetOut, WMAX);

    // R1: mid-run reset restores nominal set
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    modelReset();
    check("R1", "outValid in reset", outValid, 0);
    checkCoeffs("R1");
    rstN = 1'b1;
    runSample(11'h7FF, 0, 1'b0, "R2");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule